// File: doc/BRIEF.md
# Post-Reset Option Loader

This block runs once after every release of the external reset. It walks a reserved 256-byte window at the top of a 64K program memory, addresses FF00H through FFFFH, reading one byte per request/acknowledge handshake on a synchronous read port. A small fixed set of byte offsets inside that window is decoded into option registers. These registers choose the pull-up enables and the open-drain drive selects of the general-purpose ports. All other bytes in the window are fetched and then discarded.

While the walk is in progress, the processor is held in reset and every option output stays at its safe value: no pull-up and no open-drain. When the byte at FFFFH has been accepted, the loader raises its done flag, releases the processor reset and presents the options. The processor then starts fetching at 0000H. From that point a guard passes processor reads that fall in the program space (0000H to FEFFH). It refuses any read that falls in the option window and flags it as a fault.

An external reset that arrives in the middle of a walk discards the partial result. The walk then starts again from FF00H.

Top module: `cfg_option_loader`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `rd_req`, `load_done`, `cpu_reset_n` and every option output are 0.
- R2: The first request after reset release carries address FF00H. Each acknowledged request is followed by a request for the next higher address. `rd_addr` holds steady while a request waits for `rd_ack`.
- R3: Exactly 256 handshakes complete per load (FF00H through FFFFH). `rd_req` stays low after the last one until the next reset.
- R4: `load_done` and `cpu_reset_n` go high on the clock edge that accepts the FFFFH byte and stay high until reset. After that edge, no option output changes.
- R5: Before `load_done`, every option output is 0.
- R6: Byte offset 00H bit n (n = 0, 1) sets the Port 0 pull-up for pins 4n to 4n+3, so pull-ups are selected per nibble. Bits 7:2 are ignored.
- R7: Byte offset 01H bit n sets Port 0 pin n open-drain (1 = open-drain). Offset 02H bit n sets Port 1 pin n pull-up. Offset 03H bit n sets Port 1 pin n open-drain.
- R8: Byte offset 04H bits 3:0 set the Port 7 pull-ups per pin. Bits 7:4 are ignored.
- R9: Bytes at offsets 05H to FFH have no effect on any option output.
- R10: A reset during a load clears all options and `load_done`, and the next load starts again from FF00H.
- R11: After `load_done`, a processor read (`cpu_rd`=1) below FF00H raises `cpu_mem_rd`. A read at FF00H or above raises `cpu_cfg_fault` instead. Before `load_done`, both outputs are 0.
- R12: `boot_pc` presents the processor start address 0000H.
- R13: `load_done` rises within `LOAD_BUDGET` cycles (3 ms at the design clock) of reset release, given a memory that answers each request in a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| rd_req | output | 1 | Read request to program memory |
| rd_addr | output | 16 | Read address |
| rd_ack | input | 1 | Memory accepts request; rd_data valid this cycle |
| rd_data | input | 8 | Read data |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_addr | input | 16 | Processor read address |
| cpu_mem_rd | output | 1 | Processor read passed to memory |
| cpu_cfg_fault | output | 1 | Processor read into the option window refused |
| cpu_reset_n | output | 1 | Active-low processor reset |
| boot_pc | output | 16 | Processor start address |
| load_done | output | 1 | Option load complete |
| p0_pullup | output | 8 | Port 0 pull-up enables |
| p0_opendrain | output | 8 | Port 0 open-drain selects |
| p1_pullup | output | 8 | Port 1 pull-up enables |
| p1_opendrain | output | 8 | Port 1 open-drain selects |
| p7_pullup | output | 4 | Port 7 pull-up enables |

## Verification
The first request appears one edge after reset release. A new address appears one edge after each acknowledge. `load_done`, `cpu_reset_n` and the options change on the same edge that accepts the FFFFH byte. The guard outputs follow `cpu_rd`/`cpu_addr` combinationally.

The bench keeps a behavioural model that is updated on every rising edge from the inputs the bench itself applied. Inputs are driven 2 ns after the edge, and all outputs are compared with the model at the falling edge, so each registered result is checked in the exact cycle it is due. The bench runs loads with acknowledge latencies of 0 and 2, interrupts one load with a reset partway through, fills the ignored bytes with all ones, and probes both edges of the window boundary.

// File: rtl/optld_pkg.sv
// Package: shared state type and option byte offsets for the option loader.
// Assumes the option window is at most 256 bytes so an offset fits one byte.
package optld_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FETCH = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_e;

    // Offsets inside the window that carry option bits
    localparam int OFS_P0_PU = 0;
    localparam int OFS_P0_OD = 1;
    localparam int OFS_P1_PU = 2;
    localparam int OFS_P1_OD = 3;
    localparam int OFS_P7_PU = 4;

endpackage

// File: rtl/optld_fetch_seq.sv
// Module: walks the option window from its base upward, one byte per
// request/acknowledge handshake, and signals completion after the last byte.
// Assumes rd_data is valid in the same cycle as rd_ack.
module optld_fetch_seq
    import optld_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BASE = 'hFF00,
    parameter int WIN_LEN  = 256,
    parameter int OFS_W    = $clog2(WIN_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              byte_stb,
    output logic [OFS_W-1:0]  byte_ofs,
    output logic              done
);

    localparam logic [OFS_W-1:0]  LAST_OFS  = OFS_W'(WIN_LEN - 1);
    localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WIN_BASE + WIN_LEN - 1);

    ld_state_e           state;
    logic [OFS_W-1:0]    idx;

    // Purpose: sequence state and window offset, restarted by every reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LD_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                LD_IDLE: begin
                    state <= LD_FETCH;
                    idx   <= '0;
                end
                LD_FETCH: begin
                    if (rd_ack) begin
                        if (idx == LAST_OFS) state <= LD_DONE;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                default: state <= LD_DONE;
            endcase
        end
    end

    // Purpose: request, address and byte strobe toward the option bank
    always_comb begin
        rd_req   = (state == LD_FETCH);
        rd_addr  = BASE_ADDR + ADDR_W'(idx);
        byte_stb = rd_req && rd_ack;
        byte_ofs = idx;
        done     = (state == LD_DONE);
    end

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_addr != LAST_ADDR) |=> (rd_addr == $past(rd_addr) + 1'b1));

    p_first_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> (rd_addr == BASE_ADDR));

    p_no_req_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/optld_option_bank.sv
// Module: captures the decoded option bytes into shadow registers and shows
// them on the option outputs only once the load is done; otherwise safe zeros.
// Assumes P0_W, P1_W and P7_W do not exceed DATA_W and P0_W is a multiple of NIB_W.
module optld_option_bank
    import optld_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 8,
    parameter int P0_W   = 8,
    parameter int P1_W   = 8,
    parameter int P7_W   = 4,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [OFS_W-1:0]  byte_ofs,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              done,
    output logic [P0_W-1:0]   p0_pullup,
    output logic [P0_W-1:0]   p0_opendrain,
    output logic [P1_W-1:0]   p1_pullup,
    output logic [P1_W-1:0]   p1_opendrain,
    output logic [P7_W-1:0]   p7_pullup
);

    localparam int P0_NIBS = P0_W / NIB_W;

    logic [P0_NIBS-1:0] sh_p0_nib;
    logic [P0_W-1:0]    sh_p0_od;
    logic [P1_W-1:0]    sh_p1_pu;
    logic [P1_W-1:0]    sh_p1_od;
    logic [P7_W-1:0]    sh_p7_pu;

    // Purpose: shadow capture of the bytes at the decoded offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_p0_nib <= '0;
            sh_p0_od  <= '0;
            sh_p1_pu  <= '0;
            sh_p1_od  <= '0;
            sh_p7_pu  <= '0;
        end else if (byte_stb) begin
            case (byte_ofs)
                OFS_W'(OFS_P0_PU): sh_p0_nib <= byte_data[P0_NIBS-1:0];
                OFS_W'(OFS_P0_OD): sh_p0_od  <= byte_data[P0_W-1:0];
                OFS_W'(OFS_P1_PU): sh_p1_pu  <= byte_data[P1_W-1:0];
                OFS_W'(OFS_P1_OD): sh_p1_od  <= byte_data[P1_W-1:0];
                OFS_W'(OFS_P7_PU): sh_p7_pu  <= byte_data[P7_W-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: one pull-up enable fans out to every pin of its Port 0 nibble
    for (genvar g = 0; g < P0_NIBS; g++) begin : g_p0_nib
        assign p0_pullup[g*NIB_W +: NIB_W] = {NIB_W{done & sh_p0_nib[g]}};
    end

    // Purpose: per-pin options held at safe zeros until the load completes
    always_comb begin
        p0_opendrain = done ? sh_p0_od : '0;
        p1_pullup    = done ? sh_p1_pu : '0;
        p1_opendrain = done ? sh_p1_od : '0;
        p7_pullup    = done ? sh_p7_pu : '0;
    end

    p_frozen_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(p0_pullup) && $stable(p0_opendrain) &&
                                   $stable(p1_pullup) && $stable(p1_opendrain) &&
                                   $stable(p7_pullup)));

    p_no_capture_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !byte_stb);

endmodule

// File: rtl/optld_cpu_guard.sv
// Module: filters processor reads once the processor runs; reads below the
// option window pass, reads inside it are refused and flagged.
// Assumes the option window runs to the top of the address space.
module optld_cpu_guard #(
    parameter int ADDR_W   = 16,
    parameter int WIN_BASE = 'hFF00
) (
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              done,
    output logic              cpu_mem_rd,
    output logic              cpu_cfg_fault
);

    localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(WIN_BASE);

    logic in_window;

    // Purpose: classify the processor address against the window base
    always_comb begin
        in_window     = (cpu_addr >= BASE_ADDR);
        cpu_mem_rd    = cpu_rd && done && !in_window;
        cpu_cfg_fault = cpu_rd && done && in_window;
    end

endmodule

// File: rtl/cfg_option_loader.sv
// Module: top of the post-reset option loader. Holds the processor in reset
// while the option window is read into the option registers, then releases
// it with a start address of BOOT_PC and guards its reads.
// Assumes a memory that answers every request within a bounded time.
module cfg_option_loader
    import optld_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int WIN_BASE    = 'hFF00,
    parameter int WIN_LEN     = 256,
    parameter int P0_W        = 8,
    parameter int P1_W        = 8,
    parameter int P7_W        = 4,
    parameter int NIB_W       = 4,
    parameter int BOOT_PC     = 0,
    parameter int LOAD_BUDGET = 150000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_mem_rd,
    output logic              cpu_cfg_fault,
    output logic              cpu_reset_n,
    output logic [ADDR_W-1:0] boot_pc,
    output logic              load_done,
    output logic [P0_W-1:0]   p0_pullup,
    output logic [P0_W-1:0]   p0_opendrain,
    output logic [P1_W-1:0]   p1_pullup,
    output logic [P1_W-1:0]   p1_opendrain,
    output logic [P7_W-1:0]   p7_pullup
);

    localparam int OFS_W = $clog2(WIN_LEN);
    localparam int BUD_W = $clog2(LOAD_BUDGET + 1);

    logic             byte_stb;
    logic [OFS_W-1:0] byte_ofs;
    logic             done;
    logic [BUD_W-1:0] bud_cnt;

    optld_fetch_seq #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LEN  (WIN_LEN),
        .OFS_W    (OFS_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_ack   (rd_ack),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .byte_stb (byte_stb),
        .byte_ofs (byte_ofs),
        .done     (done)
    );

    optld_option_bank #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W),
        .P0_W   (P0_W),
        .P1_W   (P1_W),
        .P7_W   (P7_W),
        .NIB_W  (NIB_W)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_stb     (byte_stb),
        .byte_ofs     (byte_ofs),
        .byte_data    (rd_data),
        .done         (done),
        .p0_pullup    (p0_pullup),
        .p0_opendrain (p0_opendrain),
        .p1_pullup    (p1_pullup),
        .p1_opendrain (p1_opendrain),
        .p7_pullup    (p7_pullup)
    );

    optld_cpu_guard #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE)
    ) u_guard (
        .cpu_rd        (cpu_rd),
        .cpu_addr      (cpu_addr),
        .done          (done),
        .cpu_mem_rd    (cpu_mem_rd),
        .cpu_cfg_fault (cpu_cfg_fault)
    );

    // Purpose: processor reset release, load flag and fixed start address
    always_comb begin
        cpu_reset_n = done;
        load_done   = done;
        boot_pc     = ADDR_W'(BOOT_PC);
    end

    // Purpose: cycles spent loading since reset release, saturating at the budget
    always_ff @(posedge clk) begin
        if (!rst_n)                                 bud_cnt <= '0;
        else if (!done && bud_cnt != BUD_W'(LOAD_BUDGET)) bud_cnt <= bud_cnt + 1'b1;
    end

    p_budget_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bud_cnt == BUD_W'(LOAD_BUDGET)) |-> done);

    p_fetch_after_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mem_rd || cpu_cfg_fault) |-> cpu_reset_n);

    p_released_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_n |=> cpu_reset_n);

endmodule

// File: tb/cfg_option_loader_bench.sv
// Bench: behavioural reference model updated on each rising edge, compared
// with every output on each falling edge; inputs are driven 2 ns after the edge.
module cfg_option_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        cpu_rd = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_mem_rd, cpu_cfg_fault, cpu_reset_n, load_done;
    logic [15:0] boot_pc;
    logic [7:0]  p0_pullup, p0_opendrain, p1_pullup, p1_opendrain;
    logic [3:0]  p7_pullup;

    int errors = 0;
    int checks = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    logic [7:0] cfg_mem [256];
    int lat = 0;
    int wcnt = 0;
    int ack_count = 0;

    // reference model state
    int         m_st = 0;   // 0 idle, 1 fetch, 2 done
    int         m_idx = 0;
    logic [7:0] m_b [5];

    always #10 clk = ~clk;

    cfg_option_loader u_cfg_option_loader (
        .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_addr (rd_addr),
        .rd_ack (rd_ack), .rd_data (rd_data), .cpu_rd (cpu_rd), .cpu_addr (cpu_addr),
        .cpu_mem_rd (cpu_mem_rd), .cpu_cfg_fault (cpu_cfg_fault),
        .cpu_reset_n (cpu_reset_n), .boot_pc (boot_pc), .load_done (load_done),
        .p0_pullup (p0_pullup), .p0_opendrain (p0_opendrain),
        .p1_pullup (p1_pullup), .p1_opendrain (p1_opendrain), .p7_pullup (p7_pullup)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: answers a request after lat waiting cycles
    always @(posedge clk) begin
        #2;
        rd_ack = 1'b0;
        if (rst_n && rd_req) begin
            if (wcnt >= lat) begin
                rd_ack  = 1'b1;
                rd_data = cfg_mem[rd_addr[7:0]];
                wcnt    = 0;
                ack_count++;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
    end

    // Reference model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0;
            for (int i = 0; i < 5; i++) m_b[i] = 8'h00;
        end else if (m_st == 0) begin
            m_st = 1; m_idx = 0;
        end else if (m_st == 1 && rd_ack) begin
            if (m_idx < 5) m_b[m_idx] = rd_data;
            if (m_idx == 255) m_st = 2;
            else m_idx++;
        end
    end

    // Output comparison on each falling edge
    always @(negedge clk) begin
        if (chk_en && !finished) begin
            bit         d;
            logic [7:0] e_p0pu;
            d = (m_st == 2);
            e_p0pu = d ? {{4{m_b[0][1]}}, {4{m_b[0][0]}}} : 8'h00;
            check(rd_req == (m_st == 1), "R3 rd_req", 32'(rd_req), 32'(m_st == 1));
            if (m_st == 1)
                check(rd_addr == 16'hFF00 + 16'(m_idx), "R2 rd_addr", 32'(rd_addr),
                      32'(16'hFF00 + 16'(m_idx)));
            check(load_done == d, "R4 load_done", 32'(load_done), 32'(d));
            check(cpu_reset_n == d, "R4 cpu_reset_n", 32'(cpu_reset_n), 32'(d));
            check(p0_pullup == e_p0pu, "R6 p0_pullup", 32'(p0_pullup), 32'(e_p0pu));
            check(p0_opendrain == (d ? m_b[1] : 8'h00), "R7 p0_opendrain",
                  32'(p0_opendrain), 32'(d ? m_b[1] : 8'h00));
            check(p1_pullup == (d ? m_b[2] : 8'h00), "R7 p1_pullup",
                  32'(p1_pullup), 32'(d ? m_b[2] : 8'h00));
            check(p1_opendrain == (d ? m_b[3] : 8'h00), "R7 p1_opendrain",
                  32'(p1_opendrain), 32'(d ? m_b[3] : 8'h00));
            check(p7_pullup == (d ? m_b[4][3:0] : 4'h0), "R8 p7_pullup",
                  32'(p7_pullup), 32'(d ? m_b[4][3:0] : 4'h0));
            check(cpu_mem_rd == (cpu_rd && d && cpu_addr < 16'hFF00), "R11 cpu_mem_rd",
                  32'(cpu_mem_rd), 32'(cpu_rd && d && cpu_addr < 16'hFF00));
            check(cpu_cfg_fault == (cpu_rd && d && cpu_addr >= 16'hFF00), "R11 cpu_cfg_fault",
                  32'(cpu_cfg_fault), 32'(cpu_rd && d && cpu_addr >= 16'hFF00));
            check(boot_pc == 16'h0000, "R12 boot_pc", 32'(boot_pc), 32'h0);
        end
    end

    task automatic fill_cfg(input logic [7:0] b0, b1, b2, b3, b4, input bit ones);
        for (int i = 0; i < 256; i++) cfg_mem[i] = ones ? 8'hFF : 8'((i * 37 + 11) & 255);
        cfg_mem[0] = b0; cfg_mem[1] = b1; cfg_mem[2] = b2; cfg_mem[3] = b3; cfg_mem[4] = b4;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!load_done && cyc < 5000) begin @(negedge clk); cyc++; end
        @(posedge clk); #2;
    endtask

    task automatic cpu_probe(input logic [15:0] a, input bit rd);
        @(posedge clk); #2;
        cpu_rd = rd; cpu_addr = a;
        @(negedge clk); #1;
        check(cpu_mem_rd == (rd && load_done && a < 16'hFF00), "R11 probe mem_rd",
              32'(cpu_mem_rd), 32'(rd && load_done && a < 16'hFF00));
        check(cpu_cfg_fault == (rd && load_done && a >= 16'hFF00), "R11 probe fault",
              32'(cpu_cfg_fault), 32'(rd && load_done && a >= 16'hFF00));
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        summary();
    end

    initial begin
        int cyc;
        // Load 1: ack latency 0, mixed filler
        fill_cfg(8'h02, 8'hA5, 8'h3C, 8'h81, 8'hF9, 1'b0);
        lat = 0;
        tick(3);
        chk_en = 1'b1;
        @(negedge clk);
        check(rd_req == 1'b0 && load_done == 1'b0 && cpu_reset_n == 1'b0, "R1 in reset",
              32'({rd_req, load_done, cpu_reset_n}), 32'h0);
        check({p0_pullup, p0_opendrain, p1_pullup, p1_opendrain, p7_pullup} == '0,
              "R1 options in reset", 32'(p1_pullup), 32'h0);
        @(posedge clk); #2; rst_n = 1'b1; ack_count = 0;
        @(negedge clk);
        check(rd_req == 1'b0 && cpu_reset_n == 1'b0, "R1 first cycle after release",
              32'({rd_req, cpu_reset_n}), 32'h0);
        cpu_probe(16'h0000, 1'b1);   // R11 before done
        wait_done(cyc);
        check(cyc < 150000, "R13 load within budget", 32'(cyc), 32'(150000));
        check(ack_count == 256, "R3 handshake count", 32'(ack_count), 32'd256);
        check(p0_pullup == 8'hF0, "R6 upper nibble pull-up", 32'(p0_pullup), 32'hF0);
        check(p7_pullup == 4'h9, "R8 upper bits ignored", 32'(p7_pullup), 32'h9);
        tick(20);
        check(ack_count == 256, "R3 no request after done", 32'(ack_count), 32'd256);
        cpu_probe(16'h0000, 1'b1);
        cpu_probe(16'hFEFF, 1'b1);
        cpu_probe(16'hFF00, 1'b1);
        cpu_probe(16'hFFFF, 1'b1);
        cpu_probe(16'hFFFF, 1'b0);
        cpu_rd = 1'b0;

        // Load 2: ack latency 2, ignored bytes all ones
        rst_n = 1'b0;
        fill_cfg(8'hFD, 8'h5A, 8'hC3, 8'h7E, 8'h06, 1'b1);
        lat = 2;
        tick(3);
        rst_n = 1'b1; ack_count = 0;
        wait_done(cyc);
        check(ack_count == 256, "R3 handshake count slow memory", 32'(ack_count), 32'd256);
        check(p0_pullup == 8'h0F && p0_opendrain == 8'h5A && p1_pullup == 8'hC3 &&
              p1_opendrain == 8'h7E && p7_pullup == 4'h6, "R9 filler has no effect",
              32'({p0_pullup, p7_pullup}), 32'({8'h0F, 4'h6}));

        // Load 3: reset partway through, then reload new contents
        rst_n = 1'b0;
        fill_cfg(8'h03, 8'h11, 8'h22, 8'h33, 8'h04, 1'b0);
        lat = 1;
        tick(3);
        rst_n = 1'b1;
        tick(100);
        check(load_done == 1'b0 && p1_pullup == 8'h00, "R5 options safe while loading",
              32'(p1_pullup), 32'h0);
        rst_n = 1'b0;
        fill_cfg(8'h01, 8'h80, 8'h01, 8'hFF, 8'h0F, 1'b0);
        tick(2);
        @(negedge clk);
        check(load_done == 1'b0 && p0_opendrain == 8'h00, "R10 restart clears options",
              32'(p0_opendrain), 32'h0);
        @(posedge clk); #2; rst_n = 1'b1; ack_count = 0;
        @(negedge clk); @(negedge clk);
        check(rd_req && rd_addr == 16'hFF00, "R10 restart from window base",
              32'(rd_addr), 32'hFF00);
        wait_done(cyc);
        check(ack_count == 256 && p0_pullup == 8'h0F && p7_pullup == 4'hF,
              "R10 reload result", 32'({p0_pullup, p7_pullup}), 32'({8'h0F, 4'hF}));
        tick(5);
        summary();
    end

endmodule